// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block converts 32-bit virtual addresses from a core into 36-bit physical addresses. The virtual space is cut into 256 regions of 16 MB each, selected by the top eight address bits. A 256-entry direct-indexed region table holds the master copy of every mapping. Each entry holds a 12-bit physical base, a valid flag and a message-type flag. In front of it sits a 64-entry fully associative translation buffer that answers most requests in the cycle they arrive.

When the buffer misses, the region table is read. A valid entry is copied into the buffer, with the slot chosen round-robin, and the result appears one cycle later. An invalid entry produces a fault response and nothing is copied. Every response carries the message-type flag, which tells the cache that the line belongs to non-coherent shared memory used for message passing.

Software fills the region table through a write port. Any write invalidates, in the same cycle, every buffer entry that caches that region. Page walks and fault handling lie outside the block.

Top module: `xlat_unit`

## Requirements
- R1: After reset no response is signalled, `reqReady` is 1, and every region table entry is invalid, so the first request to any region faults.
- R2: The physical address is the 12-bit base of the region, followed by virtual address bits 23:0 unchanged. The region is virtual address bits 31:24.
- R3: A request that hits the buffer, made while `reqReady` is 1, gets `rspValid`=1 and `rspHit`=1 in the same cycle, with `rspFault`=0.
- R4: A buffer miss whose region table entry is valid gives no response in the request cycle. In the next cycle it gives `rspValid`=1, `rspHit`=0, `rspFault`=0 and the translation, with `reqReady`=0. The next request to that region then hits.
- R5: A buffer miss whose region table entry is invalid gives, one cycle later, `rspValid`=1, `rspFault`=1, `rspPaddr`=0 and `rspMsgType`=0. Nothing is copied into the buffer, so a repeat request faults again after the same delay.
- R6: `rspMsgType` equals the message-type flag of the entry that produced the translation, for both buffer hits and table refills.
- R7: A write to a region table entry invalidates every buffer entry that caches that region. The next request to that region misses and returns the newly written translation.
- R8: Refills fill buffer slots in round-robin order. With 64 slots, the 65th refill after reset evicts the first region refilled and keeps the second.
- R9: A request presented while `reqReady` is 0 is ignored. That cycle carries only the pending late response, and no response follows from the ignored request.
- R10: A write and a missing request to the same region in the same cycle: the response carries the table contents from before the write, and no refill happens. A later request misses and sees the new contents.
- R11: A write to one region leaves buffer entries of other regions in place, so they still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqReady | output | 1 | Unit accepts a request this cycle |
| rspValid | output | 1 | Response present this cycle |
| rspHit | output | 1 | Response came from the buffer in the request cycle |
| rspFault | output | 1 | No valid mapping exists for the region |
| rspPaddr | output | 36 | Translated physical address; zero when no response or on fault |
| rspMsgType | output | 1 | Message-passing memory flag of the translation |
| wrEn | input | 1 | Region table write strobe |
| wrIndex | input | 8 | Region number to write |
| wrBase | input | 12 | Physical base for that region |
| wrValid | input | 1 | Valid flag to store |
| wrMsgType | input | 1 | Message-type flag to store |

## Verification
The embedded properties assume that every input is at a known level after reset. They also assume that the core drops any request made while `reqReady` is low rather than expecting it to be queued. The late-response property counts a miss only when it arrives while the unit is ready. The bench drives all inputs on the falling edge with defined values. It holds `reqVaddr` steady across each request, and it raises requests during the busy cycle only to show that they are ignored.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;   // latch region table result for a late response
    logic refill;    // copy region table entry into the buffer
    logic showHit;   // drive buffer result onto the response port
    logic showLate;  // drive the captured result onto the response port
  } ctrlStrobes_t;

endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         tlbHit,
  input  logic         lutValid,
  input  logic         wrConflict,
  output ctrlStrobes_t strb,
  output logic         reqReady
);

  typedef enum logic {ST_IDLE, ST_RESP} state_t;
  state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (tlbHit) begin
            strb.showHit = 1'b1;
          end else begin
            strb.capture = 1'b1;
            strb.refill  = lutValid && !wrConflict;
            nextState    = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        strb.showLate = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

  AST_MISS_THEN_LATE: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && !tlbHit) |=> strb.showLate); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.showLate |=> !strb.showLate); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.showLate |-> (!reqReady && !strb.showHit)); // R9

endmodule

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 36,
  parameter int REGION_W    = 8,
  parameter int TLB_ENTRIES = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [VA_W-1:0]            reqVaddr,
  input  logic                       wrEn,
  input  logic [REGION_W-1:0]        wrIndex,
  input  logic [PA_W-VA_W+REGION_W-1:0] wrBase,
  input  logic                       wrValid,
  input  logic                       wrMsg,
  input  ctrlStrobes_t               strb,
  output logic                       tlbHit,
  output logic                       lutValidOut,
  output logic                       wrConflict,
  output logic [PA_W-1:0]            rspPaddr,
  output logic                       rspMsg,
  output logic                       rspFault
);

  localparam int OFF_W     = VA_W - REGION_W;
  localparam int BASE_W    = PA_W - OFF_W;
  localparam int LUT_DEPTH = 1 << REGION_W;
  localparam int PTR_W     = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

  logic [REGION_W-1:0] region;
  logic [OFF_W-1:0]    offset;
  assign region = reqVaddr[VA_W-1:OFF_W];
  assign offset = reqVaddr[OFF_W-1:0];

  // Region table
  logic [LUT_DEPTH-1:0] lutV;
  logic [LUT_DEPTH-1:0] lutM;
  logic [BASE_W-1:0]    lutB [LUT_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lutV <= '0;
    else if (wrEn) lutV[wrIndex] <= wrValid;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      lutB[wrIndex] <= wrBase;
      lutM[wrIndex] <= wrMsg;
    end
  end

  // Associative buffer
  logic [TLB_ENTRIES-1:0] tlbV, tlbVNext, tlbM, hitVec, wrMatch;
  logic [REGION_W-1:0]    tlbTag  [TLB_ENTRIES];
  logic [BASE_W-1:0]      tlbBase [TLB_ENTRIES];
  logic [PTR_W-1:0]       rrPtr;

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gEntry
    assign hitVec[g]  = tlbV[g] && (tlbTag[g] == region);
    assign wrMatch[g] = tlbV[g] && (tlbTag[g] == wrIndex);
  end

  always_comb begin
    tlbVNext = tlbV;
    if (wrEn)        tlbVNext = tlbVNext & ~wrMatch;
    if (strb.refill) tlbVNext[rrPtr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbV  <= '0;
      rrPtr <= '0;
    end else begin
      tlbV <= tlbVNext;
      if (strb.refill)
        rrPtr <= (rrPtr == PTR_W'(TLB_ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.refill) begin
      tlbTag[rrPtr]  <= region;
      tlbBase[rrPtr] <= lutB[region];
      tlbM[rrPtr]    <= lutM[region];
    end
  end

  logic [BASE_W-1:0] hitBase;
  logic              hitMsg;
  always_comb begin
    hitBase = '0;
    hitMsg  = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitBase = hitBase | tlbBase[i];
        hitMsg  = hitMsg | tlbM[i];
      end
    end
  end

  // Captured late result
  logic [PA_W-1:0] capPaddr;
  logic            capMsg, capFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPaddr <= '0;
      capMsg   <= 1'b0;
      capFault <= 1'b0;
    end else if (strb.capture) begin
      capFault <= !lutV[region];
      capPaddr <= lutV[region] ? {lutB[region], offset} : '0;
      capMsg   <= lutV[region] && lutM[region];
    end
  end

  assign tlbHit      = |hitVec;
  assign lutValidOut = lutV[region];
  assign wrConflict  = wrEn && (wrIndex == region);
  assign rspPaddr    = strb.showHit  ? {hitBase, offset} :
                       strb.showLate ? capPaddr : '0;
  assign rspMsg      = strb.showHit ? hitMsg : (strb.showLate && capMsg);
  assign rspFault    = strb.showLate && capFault;

  // Checker state for the invalidation property
  logic                lastWrEn;
  logic [REGION_W-1:0] lastWrIdx;
  logic [TLB_ENTRIES-1:0] staleVec;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastWrEn  <= 1'b0;
      lastWrIdx <= '0;
    end else begin
      lastWrEn  <= wrEn;
      lastWrIdx <= wrIndex;
    end
  end
  for (genvar s = 0; s < TLB_ENTRIES; s++) begin : gStale
    assign staleVec[s] = tlbV[s] && (tlbTag[s] == lastWrIdx);
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R3
  AST_WRITE_INVAL: assert property (@(posedge clk) disable iff (!rstN)
    lastWrEn |-> !(|staleVec)); // R7
  AST_REFILL_NEXT_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.refill && !wrEn) |=> $stable(region) |-> tlbHit); // R4

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 36,
  parameter int REGION_W    = 8,
  parameter int TLB_ENTRIES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_W-1:0]      reqVaddr,
  output logic                 reqReady,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspFault,
  output logic [PA_W-1:0]      rspPaddr,
  output logic                 rspMsgType,
  input  logic                 wrEn,
  input  logic [REGION_W-1:0]  wrIndex,
  input  logic [PA_W-VA_W+REGION_W-1:0] wrBase,
  input  logic                 wrValid,
  input  logic                 wrMsgType
);

  ctrlStrobes_t strb;
  logic tlbHit, lutValid, wrConflict;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .tlbHit     (tlbHit),
    .lutValid   (lutValid),
    .wrConflict (wrConflict),
    .strb       (strb),
    .reqReady   (reqReady)
  );

  xlat_dp #(
    .VA_W        (VA_W),
    .PA_W        (PA_W),
    .REGION_W    (REGION_W),
    .TLB_ENTRIES (TLB_ENTRIES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqVaddr    (reqVaddr),
    .wrEn        (wrEn),
    .wrIndex     (wrIndex),
    .wrBase      (wrBase),
    .wrValid     (wrValid),
    .wrMsg       (wrMsgType),
    .strb        (strb),
    .tlbHit      (tlbHit),
    .lutValidOut (lutValid),
    .wrConflict  (wrConflict),
    .rspPaddr    (rspPaddr),
    .rspMsg      (rspMsgType),
    .rspFault    (rspFault)
  );

  assign rspValid = strb.showHit || strb.showLate;
  assign rspHit   = strb.showHit;

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspValid && !rspHit && rspPaddr == '0 && !rspMsgType)); // R5
  AST_HIT_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (reqValid && reqReady && !rspFault)); // R3

endmodule

// File: tb/xlat_unit_tb.sv
module xlat_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqVaddr;
  logic        reqReady, rspValid, rspHit, rspFault, rspMsgType;
  logic [35:0] rspPaddr;
  logic        wrEn, wrValid, wrMsgType;
  logic [7:0]  wrIndex;
  logic [11:0] wrBase;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlat_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspHit(rspHit),
    .rspFault(rspFault), .rspPaddr(rspPaddr), .rspMsgType(rspMsgType),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrBase(wrBase), .wrValid(wrValid),
    .wrMsgType(wrMsgType)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        hit;
    logic        fault;
    logic [35:0] pa;
    logic        msg;
  } vec_t;

  // R2/R3/R4/R5/R6 table walk
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0004, 1'b0, 1'b0, 36'h123_000004, 1'b0},
    '{32'h10FF_FFFF, 1'b1, 1'b0, 36'h123_FFFFFF, 1'b0},
    '{32'h2012_3456, 1'b0, 1'b0, 36'hABC_123456, 1'b1},
    '{32'h2000_0000, 1'b1, 1'b0, 36'hABC_000000, 1'b1},
    '{32'h3000_0010, 1'b0, 1'b1, 36'h0,          1'b0},
    '{32'h3000_0010, 1'b0, 1'b1, 36'h0,          1'b0},
    '{32'hFFAB_CDEF, 1'b0, 1'b0, 36'hFFF_ABCDEF, 1'b0},
    '{32'h0000_0000, 1'b0, 1'b0, 36'h001_000000, 1'b1},
    '{32'hFF00_0001, 1'b1, 1'b0, 36'hFFF_000001, 1'b0}
  };

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic applyReset();
    rstN = 1'b0; reqValid = 1'b0; reqVaddr = '0;
    wrEn = 1'b0; wrIndex = '0; wrBase = '0; wrValid = 1'b0; wrMsgType = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic lutWrite(input logic [7:0] idx, input logic [11:0] base, input logic v, input logic m);
    @(negedge clk);
    wrEn = 1'b1; wrIndex = idx; wrBase = base; wrValid = v; wrMsgType = m;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReq(input logic [31:0] va, input logic expHit, input logic expFault,
                       input logic [35:0] expPa, input logic expMsg, input string rq);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va;
    #1;
    if (expHit) begin
      check(rspValid && rspHit && !rspFault, rq, {rspValid, rspHit, rspFault}, 3'b110);
      check(rspPaddr == expPa, rq, rspPaddr, expPa);
      check(rspMsgType == expMsg, rq, rspMsgType, expMsg);
      @(negedge clk);
      reqValid = 1'b0;
    end else begin
      check(!rspValid && reqReady, rq, {rspValid, reqReady}, 2'b01);
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      check(rspValid && !rspHit && (rspFault == expFault) && !reqReady, rq,
            {rspValid, rspHit, rspFault, reqReady}, {1'b1, 1'b0, expFault, 1'b0});
      check(rspPaddr == expPa, rq, rspPaddr, expPa);
      check(rspMsgType == expMsg, rq, rspMsgType, expMsg);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    applyReset();
    #1;
    // R1: reset state
    check(!rspValid && reqReady, "R1", {rspValid, reqReady}, 2'b01);
    doReq(32'h1000_0000, 1'b0, 1'b1, 36'h0, 1'b0, "R1");

    lutWrite(8'h10, 12'h123, 1'b1, 1'b0);
    lutWrite(8'h20, 12'hABC, 1'b1, 1'b1);
    lutWrite(8'hFF, 12'hFFF, 1'b1, 1'b0);
    lutWrite(8'h00, 12'h001, 1'b1, 1'b1);
    lutWrite(8'h30, 12'h333, 1'b0, 1'b1);
    lutWrite(8'h50, 12'h050, 1'b1, 1'b0);
    lutWrite(8'h60, 12'h066, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++)
      doReq(VECS[i].va, VECS[i].hit, VECS[i].fault, VECS[i].pa, VECS[i].msg,
            VECS[i].fault ? "R5" : (VECS[i].hit ? "R3 R2 R6" : "R4 R2 R6"));

    // R7: rewrite region 0x10, buffered copy must go away
    lutWrite(8'h10, 12'h456, 1'b1, 1'b1);
    doReq(32'h1000_0008, 1'b0, 1'b0, 36'h456_000008, 1'b1, "R7");
    // R11: other region untouched by that write
    doReq(32'h2000_0100, 1'b1, 1'b0, 36'hABC_000100, 1'b1, "R11");

    // R9: request during busy cycle is ignored
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 32'h6000_0002;
    #1;
    check(!rspValid, "R9", rspValid, 0);
    @(negedge clk);
    reqVaddr = 32'h2000_0000;
    #1;
    check(rspValid && !rspHit && rspPaddr == 36'h066_000002, "R9",
          {rspValid, rspHit, rspPaddr}, {2'b10, 36'h066_000002});
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    check(!rspValid, "R9", rspValid, 0);

    // R10: write and miss to the same region in the same cycle
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 32'h5000_0001;
    wrEn = 1'b1; wrIndex = 8'h50; wrBase = 12'h505; wrValid = 1'b1; wrMsgType = 1'b1;
    #1;
    check(!rspValid, "R10", rspValid, 0);
    @(negedge clk);
    reqValid = 1'b0; wrEn = 1'b0;
    #1;
    check(rspValid && rspPaddr == 36'h050_000001 && !rspMsgType, "R10",
          {rspValid, rspMsgType, rspPaddr}, {2'b10, 36'h050_000001});
    doReq(32'h5000_0001, 1'b0, 1'b0, 36'h505_000001, 1'b1, "R10");

    // R8: round-robin replacement
    applyReset();
    for (int r = 0; r <= 64; r++)
      lutWrite(8'(r), 12'h100 + 12'(r), 1'b1, r[0]);
    for (int r = 0; r <= 64; r++)
      doReq({8'(r), 24'h000ABC}, 1'b0, 1'b0, {12'h100 + 12'(r), 24'h000ABC}, r[0], "R8");
    doReq({8'd1, 24'h000ABC}, 1'b1, 1'b0, {12'h101, 24'h000ABC}, 1'b1, "R8");
    doReq({8'd0, 24'h000ABC}, 1'b0, 1'b0, {12'h100, 24'h000ABC}, 1'b0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule